// File: doc/BRIEF.md
# Data-Space Address Generation Unit

This block forms the effective byte address of every load and store of a small 8-bit processor and steers the access into one of four regions of a single unified 16-bit data space. Those regions are the general register file, the standard I/O window, the extended I/O window and internal SRAM. The address comes from one of five addressing modes:

- a full 16-bit direct address;
- a plain pointer;
- a pointer plus an unsigned 6-bit offset;
- a pointer that is decremented before use;
- a pointer that is incremented after use.

The three 16-bit pointers live in register pairs outside the block. Their current values come in on ports. When a mode changes a pointer, the new value goes back out on a writeback port.

A request is accepted on a clock edge where the strobe and `req_ready` are both high. On the following cycle the registered results appear: the one-hot region select, the region-relative offset, the store flag, the pointer writeback, and the error and out-of-range flags. An SRAM access takes two cycles. The address is formed in the accept cycle and the data moves in the next cycle. During that data cycle `req_ready` is held low, so no new request is taken.

Top module: `dspace_agu`

## Requirements
- R1: After reset `acc_valid`, `acc_region`, `err_flag`, `oor_flag` and `wb_valid` are all 0 and `req_ready` is 1.
- R2: Mode code 0 (direct) uses `req_daddr` as the address for any value of it, ignores the pointer select, and produces no pointer writeback.
- R3: Mode code 1 (indirect) uses the selected pointer as the address. Pointer select codes are X=0, Y=1, Z=2. No writeback is produced.
- R4: Mode code 2 (displacement) uses the selected Y or Z pointer plus the zero-extended 6-bit `req_disp` (0 to 63), modulo 2^16. No writeback is produced.
- R5: An illegal request raises `err_flag` for one cycle, with no access and no writeback. A request is illegal when the mode code is 5 to 7, when the pointer select is 3 in any mode other than direct, or when displacement mode is used with X.
- R6: Mode code 3 (pre-decrement) uses pointer−1 (mod 2^16) as the address. It writes the same value back, with `wb_sel` equal to the pointer select.
- R7: Mode code 4 (post-increment) uses the unchanged pointer as the address. It writes pointer+1 (mod 2^16) back, with `wb_sel` equal to the pointer select.
- R8: A valid access sets exactly one bit of `acc_region`, and `acc_offset` is the address minus the region base:
  - bit 0 for the register file, 0x0000–0x001F, base 0x0000;
  - bit 1 for standard I/O, 0x0020–0x005F, base 0x0020;
  - bit 2 for extended I/O, 0x0060–0x00FF, base 0x0060;
  - bit 3 for SRAM, 0x0100 up to 0x0100+SRAM_BYTES−1, base 0x0100.
- R9: An address at or above 0x0100+SRAM_BYTES sets `oor_flag` for one cycle with no region and no access. Any pointer writeback still takes place.
- R10: Results appear on the cycle after acceptance. After an accepted SRAM access, `req_ready` is 0 for exactly one cycle, and a request presented then is not taken until `req_ready` returns to 1. Non-SRAM accesses can be accepted on back-to-back cycles.
- R11: `acc_write` equals the `req_write` of the accepted request whenever `acc_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load/store strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mode | input | 3 | Addressing mode code (0 direct, 1 indirect, 2 displacement, 3 pre-decrement, 4 post-increment) |
| req_ptr | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| req_disp | input | 6 | Unsigned displacement |
| req_daddr | input | 16 | Direct address |
| ptr_x | input | 16 | Current X pointer |
| ptr_y | input | 16 | Current Y pointer |
| ptr_z | input | 16 | Current Z pointer |
| req_ready | output | 1 | Request can be accepted this cycle |
| acc_valid | output | 1 | Access strobe (the data cycle for SRAM) |
| acc_write | output | 1 | Access is a store |
| acc_region | output | 4 | One-hot region select |
| acc_offset | output | 16 | Region-relative address |
| oor_flag | output | 1 | Address beyond the top of SRAM |
| err_flag | output | 1 | Illegal request |
| wb_valid | output | 1 | Pointer writeback strobe |
| wb_sel | output | 2 | Pointer being written back |
| wb_value | output | 16 | New pointer value |

## Verification
Pointer writeback and region routing resolve in the same registered cycle. They can disagree, because the address used and the value written back differ by one in the pre-decrement and post-increment modes. The bench provokes this with pointers placed on every region boundary, at the SRAM top and at 0x0000/0xFFFF. For example, post-increment from 0x00FF must route to extended I/O while writing back 0x0100, and pre-decrement from 0x0000 must flag out-of-range while writing back 0xFFFF. Both outputs are compared each cycle against a bench model, under directed corners and seeded random requests. The stall cycle after an SRAM access is also exercised while a new request is held on the inputs.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

    localparam int ADDR_W   = 16;
    localparam int DISP_W   = 6;
    localparam int REGION_N = 4;

    localparam int RG_REGS = 0;
    localparam int RG_SIO  = 1;
    localparam int RG_XIO  = 2;
    localparam int RG_SRAM = 3;

    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        PS_X    = 2'd0,
        PS_Y    = 2'd1,
        PS_Z    = 2'd2,
        PS_NONE = 2'd3
    } psel_e;

    typedef struct packed {
        logic                busy;
        logic                acc_valid;
        logic                acc_write;
        logic [REGION_N-1:0] region;
        logic [ADDR_W-1:0]   offset;
        logic                oor;
        logic                err;
        logic                wb_valid;
        logic [1:0]          wb_sel;
        logic [ADDR_W-1:0]   wb_value;
    } agu_state_t;

endpackage

// File: rtl/agu_ptr_mux.sv
module agu_ptr_mux
    import dspace_pkg::*;
(
    input  logic [2:0]        mode_i,
    input  logic [1:0]        sel_i,
    input  logic [ADDR_W-1:0] ptr_x_i,
    input  logic [ADDR_W-1:0] ptr_y_i,
    input  logic [ADDR_W-1:0] ptr_z_i,
    output logic [ADDR_W-1:0] base_o,
    output logic              illegal_o
);

    logic mode_bad;
    logic uses_ptr;
    logic sel_bad;

    always_comb begin
        unique case (sel_i)
            PS_X:    base_o = ptr_x_i;
            PS_Y:    base_o = ptr_y_i;
            PS_Z:    base_o = ptr_z_i;
            default: base_o = '0;
        endcase
        mode_bad  = (mode_i > AM_POSTINC);
        uses_ptr  = (mode_i != AM_DIRECT);
        sel_bad   = (sel_i == PS_NONE) || ((mode_i == AM_DISP) && (sel_i == PS_X));
        illegal_o = mode_bad || (uses_ptr && sel_bad);
    end

endmodule

// File: rtl/agu_ea.sv
module agu_ea
    import dspace_pkg::*;
(
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] daddr_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              wb_en_o,
    output logic [ADDR_W-1:0] wb_val_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] dec_val;
    logic [ADDR_W-1:0] inc_val;
    logic [ADDR_W-1:0] dsp_val;

    always_comb begin
        dec_val  = base_i - ONE;
        inc_val  = base_i + ONE;
        dsp_val  = base_i + ADDR_W'(disp_i);
        ea_o     = base_i;
        wb_en_o  = 1'b0;
        wb_val_o = base_i;
        unique case (mode_i)
            AM_DIRECT: ea_o = daddr_i;
            AM_IND:    ea_o = base_i;
            AM_DISP:   ea_o = dsp_val;
            AM_PREDEC: begin
                ea_o     = dec_val;
                wb_en_o  = 1'b1;
                wb_val_o = dec_val;
            end
            AM_POSTINC: begin
                ea_o     = base_i;
                wb_en_o  = 1'b1;
                wb_val_o = inc_val;
            end
            default: ea_o = base_i;
        endcase
    end

endmodule

// File: rtl/agu_region.sv
module agu_region
    import dspace_pkg::*;
#(
    parameter int REG_COUNT  = 32,
    parameter int SIO_COUNT  = 64,
    parameter int XIO_COUNT  = 160,
    parameter int SRAM_BYTES = 512
) (
    input  logic [ADDR_W-1:0]   ea_i,
    output logic [REGION_N-1:0] hit_o,
    output logic [ADDR_W-1:0]   offset_o
);

    localparam int EXT_W = ADDR_W + 1;

    function automatic logic [EXT_W-1:0] bound(input int idx);
        int acc;
        acc = 0;
        if (idx > 0) acc += REG_COUNT;
        if (idx > 1) acc += SIO_COUNT;
        if (idx > 2) acc += XIO_COUNT;
        if (idx > 3) acc += SRAM_BYTES;
        return EXT_W'(acc);
    endfunction

    logic [EXT_W-1:0] ea_ext;
    assign ea_ext = {1'b0, ea_i};

    for (genvar g = 0; g < REGION_N; g++) begin : g_win
        assign hit_o[g] = (ea_ext >= bound(g)) && (ea_ext < bound(g + 1));
    end

    always_comb begin
        offset_o = '0;
        for (int i = 0; i < REGION_N; i++) begin
            if (hit_o[i]) offset_o = ea_i - bound(i)[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/dspace_agu.sv
module dspace_agu
    import dspace_pkg::*;
#(
    parameter int SRAM_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [2:0]  req_mode,
    input  logic [1:0]  req_ptr,
    input  logic [5:0]  req_disp,
    input  logic [15:0] req_daddr,
    input  logic [15:0] ptr_x,
    input  logic [15:0] ptr_y,
    input  logic [15:0] ptr_z,
    output logic        req_ready,
    output logic        acc_valid,
    output logic        acc_write,
    output logic [3:0]  acc_region,
    output logic [15:0] acc_offset,
    output logic        oor_flag,
    output logic        err_flag,
    output logic        wb_valid,
    output logic [1:0]  wb_sel,
    output logic [15:0] wb_value
);

    localparam int REG_COUNT = 32;
    localparam int SIO_COUNT = 64;
    localparam int XIO_COUNT = 160;

    agu_state_t st_d, st_q;

    logic [ADDR_W-1:0]   base;
    logic                illegal;
    logic [ADDR_W-1:0]   ea;
    logic                wb_en;
    logic [ADDR_W-1:0]   wb_val;
    logic [REGION_N-1:0] hit;
    logic [ADDR_W-1:0]   offset;
    logic                accept;

    agu_ptr_mux i_ptr_mux (
        .mode_i    (req_mode),
        .sel_i     (req_ptr),
        .ptr_x_i   (ptr_x),
        .ptr_y_i   (ptr_y),
        .ptr_z_i   (ptr_z),
        .base_o    (base),
        .illegal_o (illegal)
    );

    agu_ea i_ea (
        .mode_i   (req_mode),
        .base_i   (base),
        .disp_i   (req_disp),
        .daddr_i  (req_daddr),
        .ea_o     (ea),
        .wb_en_o  (wb_en),
        .wb_val_o (wb_val)
    );

    agu_region #(
        .REG_COUNT  (REG_COUNT),
        .SIO_COUNT  (SIO_COUNT),
        .XIO_COUNT  (XIO_COUNT),
        .SRAM_BYTES (SRAM_BYTES)
    ) i_region (
        .ea_i     (ea),
        .hit_o    (hit),
        .offset_o (offset)
    );

    assign accept = req_valid && !st_q.busy;

    always_comb begin
        st_d           = st_q;
        st_d.busy      = 1'b0;
        st_d.acc_valid = 1'b0;
        st_d.region    = '0;
        st_d.oor       = 1'b0;
        st_d.err       = 1'b0;
        st_d.wb_valid  = 1'b0;
        if (accept) begin
            if (illegal) begin
                st_d.err = 1'b1;
            end else begin
                st_d.wb_valid  = wb_en;
                st_d.wb_sel    = req_ptr;
                st_d.wb_value  = wb_val;
                st_d.region    = hit;
                st_d.acc_valid = |hit;
                st_d.oor       = ~|hit;
                st_d.offset    = offset;
                st_d.acc_write = req_write;
                st_d.busy      = hit[RG_SRAM];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready  = !st_q.busy;
    assign acc_valid  = st_q.acc_valid;
    assign acc_write  = st_q.acc_write;
    assign acc_region = st_q.region;
    assign acc_offset = st_q.offset;
    assign oor_flag   = st_q.oor;
    assign err_flag   = st_q.err;
    assign wb_valid   = st_q.wb_valid;
    assign wb_sel     = st_q.wb_sel;
    assign wb_value   = st_q.wb_value;

    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $onehot(acc_region)); // R8
    AST_IDLE_NO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (acc_region == 4'd0)); // R8
    AST_REGFILE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_region[RG_REGS]) |-> (acc_offset < 16'(REG_COUNT))); // R8
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (!acc_valid && !wb_valid && !oor_flag)); // R5
    AST_OOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oor_flag |-> (acc_region == 4'd0 && !acc_valid)); // R9
    AST_DIRECT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode == AM_DIRECT) |=> !wb_valid); // R2
    AST_SRAM_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !illegal && hit[RG_SRAM]) |=> !req_ready); // R10
    AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (req_ready && !acc_valid && !err_flag && !oor_flag && !wb_valid)); // R10
    AST_STORE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !illegal && |hit) |=> (acc_write == $past(req_write))); // R11

endmodule

// File: tb/test_dspace_agu.sv
module test_dspace_agu;

    localparam int CLK_PERIOD = 10;
    localparam int SRAM_BYTES = 512;
    localparam int SRAM_TOP   = 256 + SRAM_BYTES;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [1:0]  req_ptr = '0;
    logic [5:0]  req_disp = '0;
    logic [15:0] req_daddr = '0;
    logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
    logic        req_ready, acc_valid, acc_write, oor_flag, err_flag, wb_valid;
    logic [3:0]  acc_region;
    logic [15:0] acc_offset, wb_value;
    logic [1:0]  wb_sel;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dspace_agu #(.SRAM_BYTES(SRAM_BYTES)) i_dspace_agu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mode(req_mode), .req_ptr(req_ptr), .req_disp(req_disp), .req_daddr(req_daddr),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .req_ready(req_ready),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_region(acc_region),
        .acc_offset(acc_offset), .oor_flag(oor_flag), .err_flag(err_flag),
        .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_value(wb_value)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, got, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R5";
        endcase
    endfunction

    // Drives one request, checks the registered result one cycle later, then idles one cycle.
    task automatic run_req(input logic [2:0] m, input logic [1:0] p, input logic [5:0] d,
                           input logic [15:0] da, input logic w);
        logic        bad, e_acc, e_oor, e_wb;
        logic [15:0] bs, ea, e_off, e_wbv;
        logic [3:0]  e_reg;
        int          eai;
        string       rq;
        rq  = req_of(m);
        bad = (m > 3'd4) || (m != 3'd0 && (p == 2'd3 || (m == 3'd2 && p == 2'd0)));
        bs  = (p == 2'd0) ? ptr_x : (p == 2'd1) ? ptr_y : (p == 2'd2) ? ptr_z : 16'h0;
        case (m)
            3'd0: ea = da;
            3'd2: ea = bs + {10'd0, d};
            3'd3: ea = bs - 16'd1;
            default: ea = bs;
        endcase
        e_wb  = !bad && (m == 3'd3 || m == 3'd4);
        e_wbv = (m == 3'd3) ? bs - 16'd1 : bs + 16'd1;
        eai   = int'(ea);
        e_reg = 4'd0; e_off = 16'd0; e_oor = 1'b0;
        if (!bad) begin
            if (eai < 32)            begin e_reg = 4'b0001; e_off = ea; end
            else if (eai < 96)       begin e_reg = 4'b0010; e_off = ea - 16'h20; end
            else if (eai < 256)      begin e_reg = 4'b0100; e_off = ea - 16'h60; end
            else if (eai < SRAM_TOP) begin e_reg = 4'b1000; e_off = ea - 16'h100; end
            else e_oor = 1'b1;
        end
        e_acc = (e_reg != 4'd0);
        req_valid = 1'b1; req_mode = m; req_ptr = p; req_disp = d; req_daddr = da; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bad ? "R5" : rq, "err_flag", err_flag, bad);
        chk(e_oor ? "R9" : "R8", "acc_region", acc_region, e_reg);
        chk("R9", "oor_flag", oor_flag, e_oor);
        chk(rq, "acc_valid", acc_valid, e_acc);
        if (e_acc) begin
            chk("R8", "acc_offset", acc_offset, e_off);
            chk("R11", "acc_write", acc_write, w);
        end
        chk(rq, "wb_valid", wb_valid, e_wb);
        if (e_wb) begin
            chk(rq, "wb_value", wb_value, e_wbv);
            chk(rq, "wb_sel", wb_sel, p);
        end
        chk("R10", "req_ready", req_ready, !(e_reg[3]));
        @(negedge clk);
    endtask

    function automatic logic [15:0] pick_ptr();
        case ($urandom % 5)
            0: return 16'($urandom);
            1: return 16'($urandom % 4);
            2: return 16'(16'hFFFC + ($urandom % 4));
            3: return 16'(32 * ($urandom % 4) + ($urandom % 3)) - 16'd1;
            default: return 16'(SRAM_TOP - 2 + ($urandom % 4));
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "acc_valid", acc_valid, 0);
        chk("R1", "acc_region", acc_region, 0);
        chk("R1", "err_flag", err_flag, 0);
        chk("R1", "oor_flag", oor_flag, 0);
        chk("R1", "wb_valid", wb_valid, 0);
        chk("R1", "req_ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 direct across regions, top of SRAM, beyond
        run_req(3'd0, 2'd3, 6'd0, 16'h001F, 1'b0);
        run_req(3'd0, 2'd0, 6'd0, 16'h0020, 1'b1);
        run_req(3'd0, 2'd1, 6'd0, 16'h00FF, 1'b0);
        run_req(3'd0, 2'd2, 6'd0, 16'(SRAM_TOP - 1), 1'b1);
        run_req(3'd0, 2'd0, 6'd0, 16'(SRAM_TOP), 1'b0);
        run_req(3'd0, 2'd0, 6'd0, 16'hFFFF, 1'b0);
        // R3 indirect
        ptr_x = 16'h005F; ptr_y = 16'h0060; ptr_z = 16'h0100;
        run_req(3'd1, 2'd0, 6'd0, 16'h0, 1'b0);
        run_req(3'd1, 2'd1, 6'd0, 16'h0, 1'b1);
        run_req(3'd1, 2'd2, 6'd0, 16'h0, 1'b0);
        // R4 displacement, max offset and wrap
        ptr_y = 16'h00C1; ptr_z = 16'hFFF0;
        run_req(3'd2, 2'd1, 6'd63, 16'h0, 1'b0);
        run_req(3'd2, 2'd2, 6'd63, 16'h0, 1'b1);
        // R5 illegal combinations
        run_req(3'd2, 2'd0, 6'd5, 16'h0, 1'b0);
        run_req(3'd1, 2'd3, 6'd0, 16'h0, 1'b0);
        run_req(3'd6, 2'd1, 6'd0, 16'h0, 1'b0);
        // R6 / R7 boundary crossings and wrap
        ptr_x = 16'h0000; ptr_y = 16'h0100; ptr_z = 16'h00FF;
        run_req(3'd3, 2'd0, 6'd0, 16'h0, 1'b0);
        run_req(3'd3, 2'd1, 6'd0, 16'h0, 1'b1);
        run_req(3'd4, 2'd2, 6'd0, 16'h0, 1'b0);
        ptr_x = 16'hFFFF;
        run_req(3'd4, 2'd0, 6'd0, 16'h0, 1'b0);

        // R10 stall: SRAM access, new request held during the data cycle
        ptr_z = 16'h0150;
        req_valid = 1'b1; req_mode = 3'd1; req_ptr = 2'd2; req_write = 1'b1;
        @(negedge clk);
        chk("R10", "sram acc_valid", acc_valid, 1);
        chk("R10", "sram region", acc_region, 4'b1000);
        chk("R10", "ready in data cycle", req_ready, 0);
        req_mode = 3'd0; req_daddr = 16'h0005; req_write = 1'b0;
        @(negedge clk);
        chk("R10", "held req not taken", acc_valid, 0);
        chk("R10", "ready back", req_ready, 1);
        @(negedge clk);
        chk("R10", "held req taken", acc_region, 4'b0001);
        chk("R10", "held req offset", acc_offset, 16'h0005);
        // back-to-back non-SRAM accesses
        req_daddr = 16'h0030;
        @(negedge clk);
        chk("R10", "b2b second region", acc_region, 4'b0010);
        chk("R10", "b2b acc_valid", acc_valid, 1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R10", "idle after b2b", acc_valid, 0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            ptr_x = pick_ptr(); ptr_y = pick_ptr(); ptr_z = pick_ptr();
            run_req(3'($urandom % 8), 2'($urandom % 4), 6'($urandom), pick_ptr(), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule